// File: doc/BRIEF.md
# Sector Erase Queue with Timeout Window

This block sits on the device side of a byte-wide flash interface. It watches the decoded write stream for the six-write sector-erase command. Once that command is accepted it opens an acceptance window. Each further write of the sector-erase code during the window adds the sector named by its address to a bitmap and starts the window again. Several sectors can therefore be gathered into one parallel erase without repeating the unlock cycles.

When the window runs out with no new sector code, the embedded erase starts. A preconditioning phase first drives the selected cells to 00h. Erase pulses follow, and each pulse is followed by one verify cycle that samples the array's erased indication. A pass returns the block to read mode and clears the bitmap. If a fixed number of pulses all fail, the block stays busy with the error flag set until a reset code is written. Throughout, the block presents a status byte for polling reads. The array itself is outside the block; only the operation request to it (`array_op`) is produced here.

Top module: `sect_erase_queue`

## Requirements
- R1: During and after reset `sect_mask` is 0, `erase_busy` is 0, `array_op` is 0 and `status` is 8'h80.
- R2: The writes AAh@555h, 55h@AAAh, 80h@555h, AAh@555h, 55h@AAAh, then 30h at any address are compared on the low 12 address bits, and the last write's top SECT_W address bits name the sector. Together they set `sect_mask` to that sector's one-hot bit and raise `erase_busy`, with status bits 3 and 7 at 0.
- R3: Any write in that sequence with wrong data or address abandons it, and the remaining writes start nothing.
- R4: A 30h write while the window is open ORs its sector into `sect_mask` and restarts the window. The erase starts exactly WIN_CYCLES cycles after the last accepted sector code.
- R5: Writes of any other data during the window change neither `sect_mask` nor the window timing.
- R6: Status bit 3 is 0 while the window counts and 1 from its expiry until the block returns to read mode.
- R7: Status bit 6 inverts after every cycle with `rd_en` high while `erase_busy` is high. It holds its value while the block is idle.
- R8: After the window, `array_op` is 1 (program to 00h) for PRE_CYCLES cycles. Then come erase pulses with `array_op` = 2 for PULSE_CYCLES cycles each, and each pulse is followed by one verify cycle with `array_op` = 0.
- R9: A verify cycle with `cell_erased` high ends the erase at the next edge. `erase_busy` falls, `sect_mask` clears and status bit 7 reads 1.
- R10: After MAX_PULSES failed verifies, status bit 5 reads 1 and `erase_busy` stays high. Only a write of F0h returns the block to read mode, with the mask cleared.
- R11: Writes during the erase phase are ignored, including a complete new erase sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Decoded write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Status read strobe, one cycle per read |
| cell_erased | input | 1 | Array verify result, sampled in verify cycles |
| sect_mask | output | 2**SECT_W | Bitmap of sectors queued for erase |
| erase_busy | output | 1 | High from command acceptance until completion or reset code |
| status | output | 8 | Poll byte: bit7 done, bit6 toggle, bit5 error, bit3 window expired |
| array_op | output | 2 | Array request: 0 none, 1 program to 00h, 2 erase pulse |

## Verification
The assertions check several properties on every cycle:
- the mask only grows while busy and is empty when idle;
- the window-expired flag never falls back during an erase;
- the toggle bit flips on every busy read and never while idle;
- the array is driven only after the window has expired;
- an error flag always comes with busy and an idle array.

Only the bench scenarios can show the rest:
- exact cycle counts of the window, preconditioning, pulse and verify phases;
- the window restarting after each added sector, across every combination of sectors;
- abandonment of the command at each of its six positions;
- failure after the pulse limit and recovery by the reset code.

// File: rtl/sect_erase_pkg.sv
// Shared codes, addresses and state types for the sector erase queue.
package sect_erase_pkg;
    typedef enum logic [1:0] {OP_NONE = 2'd0, OP_ZERO = 2'd1, OP_PULSE = 2'd2} arr_op_e;
    typedef enum logic [1:0] {Q_READ, Q_WINDOW, Q_ERASE} queue_st_e;
    typedef enum logic [2:0] {E_IDLE, E_PRE, E_PULSE, E_CHK, E_FAIL} eng_st_e;

    localparam logic [7:0]  CODE_KEY_A  = 8'hAA;
    localparam logic [7:0]  CODE_KEY_B  = 8'h55;
    localparam logic [7:0]  CODE_SETUP  = 8'h80;
    localparam logic [7:0]  CODE_SECTOR = 8'h30;
    localparam logic [7:0]  CODE_RESET  = 8'hF0;
    localparam logic [11:0] ADDR_KEY_A  = 12'h555;
    localparam logic [11:0] ADDR_KEY_B  = 12'hAAA;
endpackage

// File: rtl/sect_cmd_decode.sv
// Tracks the six-write sector-erase command while enabled.
// Assumes one write per wr_en cycle; the unlock addresses are compared on
// the low 12 bits only, and the final write may target any address.
module sect_cmd_decode #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              confirm
);
    import sect_erase_pkg::*;

    localparam logic [2:0] LAST_STEP = 3'd5;

    logic [2:0]  step;
    logic [11:0] want_addr;
    logic [7:0]  want_data;
    logic        match;

    // Expected address and data for the current position in the command.
    always_comb begin
        case (step)
            3'd0:    begin want_addr = ADDR_KEY_A; want_data = CODE_KEY_A;  end
            3'd1:    begin want_addr = ADDR_KEY_B; want_data = CODE_KEY_B;  end
            3'd2:    begin want_addr = ADDR_KEY_A; want_data = CODE_SETUP;  end
            3'd3:    begin want_addr = ADDR_KEY_A; want_data = CODE_KEY_A;  end
            3'd4:    begin want_addr = ADDR_KEY_B; want_data = CODE_KEY_B;  end
            default: begin want_addr = '0;         want_data = CODE_SECTOR; end
        endcase
        match   = (wr_data == want_data) && ((step == LAST_STEP) || (wr_addr[11:0] == want_addr));
        confirm = enable && wr_en && match && (step == LAST_STEP);
    end

    // Advance on a matching write, fall back to the start on anything else (R3).
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            step <= '0;
        end else if (wr_en) begin
            step <= (match && step != LAST_STEP) ? step + 3'd1 : 3'd0;
        end
    end
endmodule

// File: rtl/sect_window_timer.sv
// Counts the acceptance window. A load restarts the count; expire is high
// in the last running cycle of the window unless a load arrives with it.
// Assumes WIN_CYCLES >= 1.
module sect_window_timer #(
    parameter int WIN_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expire
);
    localparam int CNT_W = $clog2(WIN_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIN_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Restart on load, count while the window is open.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && !load && (cnt == LAST_CNT);
endmodule

// File: rtl/sect_erase_engine.sv
// Models the embedded erase: preconditioning, then erase pulses each
// followed by a one-cycle verify. Stops in a failed state after MAX_PULSES
// failed verifies until clear. Assumes start only arrives while idle.
module sect_erase_engine #(
    parameter int PRE_CYCLES   = 64,
    parameter int PULSE_CYCLES = 200,
    parameter int MAX_PULSES   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       clear,
    input  logic       cell_erased,
    output logic [1:0] op,
    output logic       done,
    output logic       failed
);
    import sect_erase_pkg::*;

    localparam int LONGEST = (PRE_CYCLES > PULSE_CYCLES) ? PRE_CYCLES : PULSE_CYCLES;
    localparam int TIM_W   = $clog2(LONGEST + 1);
    localparam int NP_W    = $clog2(MAX_PULSES + 1);
    localparam logic [TIM_W-1:0] PRE_LAST   = TIM_W'(PRE_CYCLES - 1);
    localparam logic [TIM_W-1:0] PULSE_LAST = TIM_W'(PULSE_CYCLES - 1);
    localparam logic [NP_W-1:0]  NP_LIMIT   = NP_W'(MAX_PULSES);

    eng_st_e          st;
    logic [TIM_W-1:0] tim;
    logic [NP_W-1:0]  npulse;

    // Phase sequencing: preconditioning, pulse, verify, retry or fail (R8, R10).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= E_IDLE;
            tim    <= '0;
            npulse <= '0;
        end else begin
            case (st)
                E_IDLE: if (start) begin
                    st     <= E_PRE;
                    tim    <= '0;
                    npulse <= '0;
                end
                E_PRE: if (tim == PRE_LAST) begin
                    st     <= E_PULSE;
                    tim    <= '0;
                    npulse <= npulse + 1'b1;
                end else begin
                    tim <= tim + 1'b1;
                end
                E_PULSE: if (tim == PULSE_LAST) begin
                    st <= E_CHK;
                end else begin
                    tim <= tim + 1'b1;
                end
                E_CHK: if (cell_erased) begin
                    st <= E_IDLE;
                end else if (npulse == NP_LIMIT) begin
                    st <= E_FAIL;
                end else begin
                    st     <= E_PULSE;
                    tim    <= '0;
                    npulse <= npulse + 1'b1;
                end
                E_FAIL: if (clear) st <= E_IDLE;
                default: st <= E_IDLE;
            endcase
        end
    end

    // Array request and completion flags from the phase.
    always_comb begin
        case (st)
            E_PRE:   op = OP_ZERO;
            E_PULSE: op = OP_PULSE;
            default: op = OP_NONE;
        endcase
        done   = (st == E_CHK) && cell_erased;
        failed = (st == E_FAIL);
    end
endmodule

// File: rtl/sect_erase_queue.sv
// Sector erase queue top: accepts the sector-erase command, gathers more
// sectors inside a restartable window, then runs the erase engine and
// presents the poll status byte. Assumes ADDR_W >= 12 + SECT_W is not
// required; the sector index is the top SECT_W address bits.
module sect_erase_queue #(
    parameter int ADDR_W       = 16,
    parameter int SECT_W       = 3,
    parameter int WIN_CYCLES   = 5000,
    parameter int PRE_CYCLES   = 64,
    parameter int PULSE_CYCLES = 200,
    parameter int MAX_PULSES   = 8,
    localparam int NUM_SECT    = 1 << SECT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [7:0]          wr_data,
    input  logic                rd_en,
    input  logic                cell_erased,
    output logic [NUM_SECT-1:0] sect_mask,
    output logic                erase_busy,
    output logic [7:0]          status,
    output logic [1:0]          array_op
);
    import sect_erase_pkg::*;

    queue_st_e           qst;
    logic                confirm, add, expire, done, failed, clear, toggle;
    logic [SECT_W-1:0]   sect_idx;
    logic [NUM_SECT-1:0] sect_hit;

    assign sect_idx = wr_addr[ADDR_W-1 -: SECT_W];

    // One-hot decode of the addressed sector.
    for (genvar i = 0; i < NUM_SECT; i++) begin : g_hit
        assign sect_hit[i] = (sect_idx == SECT_W'(i));
    end

    sect_cmd_decode #(.ADDR_W(ADDR_W)) i_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (qst == Q_READ),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .confirm (confirm)
    );

    assign add   = (qst == Q_WINDOW) && wr_en && (wr_data == CODE_SECTOR);
    assign clear = failed && wr_en && (wr_data == CODE_RESET);

    sect_window_timer #(.WIN_CYCLES(WIN_CYCLES)) i_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (confirm || add),
        .run    (qst == Q_WINDOW),
        .expire (expire)
    );

    sect_erase_engine #(
        .PRE_CYCLES   (PRE_CYCLES),
        .PULSE_CYCLES (PULSE_CYCLES),
        .MAX_PULSES   (MAX_PULSES)
    ) i_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (expire),
        .clear       (clear),
        .cell_erased (cell_erased),
        .op          (array_op),
        .done        (done),
        .failed      (failed)
    );

    // Queue state and sector bitmap (R2, R4, R9, R10).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qst       <= Q_READ;
            sect_mask <= '0;
        end else begin
            case (qst)
                Q_READ: if (confirm) begin
                    qst       <= Q_WINDOW;
                    sect_mask <= sect_hit;
                end
                Q_WINDOW: begin
                    if (add)    sect_mask <= sect_mask | sect_hit;
                    if (expire) qst <= Q_ERASE;
                end
                Q_ERASE: if (done || clear) begin
                    qst       <= Q_READ;
                    sect_mask <= '0;
                end
                default: qst <= Q_READ;
            endcase
        end
    end

    // Toggle bit flips on each status read while busy (R7).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            toggle <= 1'b0;
        end else if (rd_en && erase_busy) begin
            toggle <= ~toggle;
        end
    end

    assign erase_busy = (qst != Q_READ);

    // Poll byte: done, toggle, error, window expired (R6).
    assign status = {~erase_busy, toggle, failed, 1'b0, (qst == Q_ERASE), 3'b000};
endmodule

// File: rtl/sect_erase_queue_chk.sv
// Cycle-by-cycle properties of the sector erase queue, seen at its ports.
module sect_erase_queue_chk #(
    parameter int NUM_SECT = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd_en,
    input logic [NUM_SECT-1:0] sect_mask,
    input logic                erase_busy,
    input logic [7:0]          status,
    input logic [1:0]          array_op
);
    // R2
    start_single_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_busy) |-> ($countones(sect_mask) == 1));

    // R4
    mask_grows_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_busy && $past(erase_busy)) |-> ((sect_mask & $past(sect_mask)) == $past(sect_mask)));

    // R6
    expired_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3] && erase_busy) |=> (status[3] || !erase_busy));

    // R6
    expired_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[3] |-> !status[7]);

    // R7
    toggle_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_busy && rd_en) |=> (status[6] != $past(status[6])));

    // R7
    toggle_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !erase_busy |=> (status[6] == $past(status[6])));

    // R8
    array_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (array_op != 2'd0) |-> status[3]);

    // R9
    idle_mask_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !erase_busy |-> ((sect_mask == '0) && status[7]));

    // R10
    error_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[5] |-> (erase_busy && array_op == 2'd0));
endmodule

bind sect_erase_queue sect_erase_queue_chk #(.NUM_SECT(NUM_SECT)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .sect_mask  (sect_mask),
    .erase_busy (erase_busy),
    .status     (status),
    .array_op   (array_op)
);

// File: tb/test_sect_erase_queue.sv
// Sweeps sectors, sector combinations, abort positions and pulse counts on
// a small configuration; expected timing is computed from the parameters.
module test_sect_erase_queue;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 16;
    localparam int SW  = 3;
    localparam int NS  = 1 << SW;
    localparam int WIN = 8;
    localparam int PRE = 3;
    localparam int PUL = 4;
    localparam int MAXP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          rd_en = 1'b0;
    logic          cell_erased = 1'b0;
    logic [NS-1:0] sect_mask;
    logic          erase_busy;
    logic [7:0]    status;
    logic [1:0]    array_op;

    int n_chk = 0;
    int n_fail = 0;
    int need = 1;
    int pulses_seen = 0;
    logic [1:0] prev_op = 2'd0;

    sect_erase_queue #(
        .ADDR_W(AW), .SECT_W(SW), .WIN_CYCLES(WIN),
        .PRE_CYCLES(PRE), .PULSE_CYCLES(PUL), .MAX_PULSES(MAXP)
    ) i_sect_erase_queue (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .cell_erased(cell_erased),
        .sect_mask(sect_mask), .erase_busy(erase_busy), .status(status),
        .array_op(array_op)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Array model: reports erased once the required number of pulses has been seen.
    always @(negedge clk) begin
        if (!erase_busy) begin
            pulses_seen = 0;
            cell_erased = 1'b0;
        end else begin
            if (array_op == 2'd2 && prev_op != 2'd2) pulses_seen++;
            cell_erased = (pulses_seen >= need);
        end
        prev_op = array_op;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic rd();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Six-write command; position bad (0..5) gets corrupted data, -1 for none.
    task automatic send_seq(input int sec, input int bad);
        logic [AW-1:0] a [6];
        logic [7:0]    d [6];
        a[0] = 16'h0555; d[0] = 8'hAA;
        a[1] = 16'h0AAA; d[1] = 8'h55;
        a[2] = 16'h0555; d[2] = 8'h80;
        a[3] = 16'h0555; d[3] = 8'hAA;
        a[4] = 16'h0AAA; d[4] = 8'h55;
        a[5] = AW'(sec << (AW - SW)); d[5] = 8'h30;
        for (int i = 0; i < 6; i++) wr(a[i], (i == bad) ? (d[i] ^ 8'h01) : d[i]);
    endtask

    // Follows one erase from the current cycle and checks each phase length.
    task automatic run_erase(input int exp_win, input int need_p, input logic [NS-1:0] exp_mask);
        int cw = 0, cp = 0, ce = 0, cc = 0, n_exp;
        bit mask_ok = 1'b1;
        bit failed_seen = 1'b0;
        need = need_p;
        n_exp = (need_p <= MAXP) ? need_p : MAXP;
        for (int g = 0; g < 400; g++) begin
            if (!erase_busy) break;
            if (sect_mask != exp_mask) mask_ok = 1'b0;
            if (status[5]) begin failed_seen = 1'b1; break; end
            if (!status[3]) cw++;
            else if (array_op == 2'd1) cp++;
            else if (array_op == 2'd2) ce++;
            else cc++;
            @(negedge clk);
        end
        chk(mask_ok, "R4 mask held through erase", 0, 0);
        chk(cw == exp_win, "R4 window length", cw, exp_win);
        chk(cp == PRE, "R8 precondition cycles", cp, PRE);
        chk(ce == n_exp * PUL, "R8 pulse cycles", ce, n_exp * PUL);
        chk(cc == n_exp, "R8 verify cycles", cc, n_exp);
        if (need_p <= MAXP) begin
            chk(!failed_seen && !erase_busy, "R9 busy cleared", erase_busy, 0);
            chk(sect_mask == '0, "R9 mask cleared", sect_mask, 0);
            chk((status & 8'hBF) == 8'h80, "R9 status done", status & 8'hBF, 8'h80);
        end else begin
            chk(failed_seen && erase_busy && status[5], "R10 error flag", status, 8'h28);
            wr(16'h0000, 8'h30);
            chk(erase_busy && status[5] && sect_mask == exp_mask, "R10 non-reset write ignored",
                sect_mask, exp_mask);
            wr(16'h0000, 8'hF0);
            chk(!erase_busy && sect_mask == '0 && !status[5], "R10 reset code recovers",
                {erase_busy, status[5]}, 0);
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog: actual 200000 cycles expected fewer");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic t0;
        int   first;
        repeat (3) @(negedge clk);
        chk(sect_mask == '0 && !erase_busy && status == 8'h80 && array_op == 2'd0,
            "R1 state in reset", status, 8'h80);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sect_mask == '0 && !erase_busy && status == 8'h80 && array_op == 2'd0,
            "R1 state after reset", status, 8'h80);

        // R3: corrupt each position of the command for every sector.
        for (int s = 0; s < NS; s++) begin
            for (int b = 0; b < 6; b++) begin
                send_seq(s, b);
                @(negedge clk);
                chk(!erase_busy && sect_mask == '0, "R3 abandoned command", sect_mask, 0);
            end
        end

        // R2, R8, R9: every sector with every passing pulse count.
        for (int s = 0; s < NS; s++) begin
            for (int n = 1; n <= MAXP; n++) begin
                send_seq(s, -1);
                chk(sect_mask == NS'(1 << s), "R2 one-hot mask", sect_mask, 1 << s);
                chk(erase_busy && !status[3] && !status[7], "R2 window status", status, 0);
                run_erase(WIN, n, NS'(1 << s));
            end
        end

        // R4: every sector combination, added with gaps shorter than the window.
        for (int m = 1; m < (1 << NS); m++) begin
            first = 0;
            while (!m[first]) first++;
            send_seq(first, -1);
            for (int b = first + 1; b < NS; b++) begin
                if (m[b]) begin
                    repeat ((b % 3) + 1) @(negedge clk);
                    wr(AW'(b << (AW - SW)), 8'h30);
                end
            end
            chk(sect_mask == NS'(m), "R4 queued mask", sect_mask, m);
            run_erase(WIN, 1, NS'(m));
        end

        // R5: other data in the window neither adds nor restarts.
        send_seq(2, -1);
        wr(AW'(5 << (AW - SW)), 8'h80);
        wr(AW'(6 << (AW - SW)), 8'hAA);
        chk(sect_mask == NS'(8'h04), "R5 mask unchanged", sect_mask, 8'h04);
        run_erase(WIN - 2, 1, NS'(8'h04));

        // R7: reads toggle bit 6 while busy, not while idle.
        send_seq(1, -1);
        t0 = status[6];
        rd();
        chk(status[6] == !t0, "R7 first read toggles", status[6], !t0);
        rd();
        chk(status[6] == t0, "R7 second read toggles", status[6], t0);
        run_erase(WIN - 2, 2, NS'(8'h02));
        t0 = status[6];
        rd();
        chk(status[6] == t0, "R7 idle read holds", status[6], t0);

        // R6, R11: a full command during the erase phase is ignored.
        need = 3;
        send_seq(2, -1);
        repeat (WIN) @(negedge clk);
        chk(status[3] && erase_busy, "R6 expired flag set", status[3], 1);
        send_seq(5, -1);
        chk(sect_mask == NS'(8'h04) && status[3], "R11 writes ignored in erase", sect_mask, 8'h04);
        for (int g = 0; g < 100 && erase_busy; g++) @(negedge clk);
        chk(!erase_busy && sect_mask == '0 && !status[3], "R6 flag cleared at completion",
            status, 8'h80);

        // R10: never erased, fails after the pulse limit.
        send_seq(4, -1);
        run_erase(WIN, MAXP + 1, NS'(8'h10));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule